// File: doc/BRIEF.md
# Rate-Adjustable Cycle-to-Nanosecond Timecounter

This block turns a free-running cycle count into a nanosecond time of day. It keeps three pieces of state: the cycle value seen at the last fold, a nanosecond accumulator, and the sub-nanosecond remainder left by the last fold. When a read is asked for, the block takes the cycles elapsed since the last fold, multiplies them by a programmable rate word and shifts right by a fixed amount. The integer part goes into the accumulator and the fractional part is kept for the next fold. At the nominal rate word, 2^31 with a shift of 28, one counter tick is worth exactly 8 ns, which matches a 125 MHz counter.

Software-facing control drives four operations through one request channel: read (fold and return the time), set (load an absolute time and re-latch the counter), offset (add a signed nanosecond amount) and rate trim (take a signed scaled-ppm correction). A rate trim first folds the elapsed cycles at the old rate. It then converts the correction into a rate-word offset using the exact ratio 512/15625 and loads the new word. The counter must be folded at least once every 2^33 ticks, roughly every 68.7 s. A refresh read about once a minute is enough.

The request and response channels are valid/ready. `req_ready` is high only when no operation is in flight, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The counter value and the argument are captured on that edge. Each operation produces one response. `rsp_valid` stays high, with `rsp_time` frozen, until `rsp_ready` is seen high on a clock edge. No further request is taken until that happens, so a slow consumer stalls the request side.

Top module: `cyc_ns_timecounter`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, the time is 0, the last-fold cycle value is 0, the remainder is 0 and the rate word is nominal (2^31), so the first read at count N returns 8·N.
- R2: A read (op code 0) computes P = delta·rate + remainder, adds floor(P / 2^28) to the time, keeps P mod 2^28 as the new remainder, latches the current count, and returns the new time.
- R3: The elapsed-cycle delta is the current count minus the last-fold count, taken modulo 2^64, so a counter wrap between folds yields the true tick distance.
- R4: A set (op code 1) loads the argument as the time, latches the current count as the last-fold value, clears the remainder and returns the loaded time.
- R5: An offset (op code 2) adds the 64-bit two's-complement argument to the time and leaves the rate word, the remainder and the last-fold count unchanged.
- R6: A rate trim (op code 3) takes argument bits [31:0] as a signed scaled-ppm value s and sets the rate word to 2^31 + trunc(s·512 / 15625), with the division rounded toward zero.
- R7: Before conversion, s is clamped to ±2,097,152,000, which equals ±32,000,000 ppb. The rate word therefore never leaves 2^31 ± 68,719,476.
- R8: A rate trim first folds the elapsed cycles at the old rate word, exactly as a read does. Its response returns that folded time, and the new rate applies only from the next fold.
- R9: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response is consumed, and each accepted request takes effect exactly once.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_time` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_count | input | 64 | Free-running tick counter |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation: 0 read, 1 set, 2 offset, 3 rate trim |
| req_arg | input | 64 | Time for set, signed offset, or scaled-ppm value in [31:0] |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_time | output | 64 | Nanosecond time after the operation |

## Verification
Two events can meet in the same cycle: the end of one operation, while its response is still held, and the arrival of the next request. The bench provokes this by issuing an offset and keeping `rsp_ready` low for several cycles, with a second offset already presented on the request side. It judges the result by checking, on every stalled cycle, that `req_ready` stays low and `rsp_time` stays frozen, and then that the second offset is applied exactly once after release. The other meeting point is a rate trim, where the fold and the rate change happen in one operation. The bench checks this with reads whose expected value uses the old rate for cycles before the trim and the new rate only after it.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_ADJ  = 2'd2,
    OP_FINE = 2'd3
  } tc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_ADD,
    ST_EXEC,
    ST_DIV,
    ST_RESP
  } tc_state_e;
endpackage

// File: rtl/tc_rate_div.sv
// Converts a signed scaled-ppm correction into a new rate word.
// Clamps the input, then runs a restoring divider one quotient bit per cycle.
module tc_rate_div #(
  parameter int unsigned PPM_W   = 32,
  parameter int unsigned MULT_W  = 32,
  parameter longint unsigned NOM = 64'h8000_0000,
  parameter int unsigned LIMIT   = 2097152000,
  parameter int unsigned NUM_SH  = 9,
  parameter int unsigned DEN     = 15625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PPM_W-1:0]  sppm,
  output logic              busy,
  output logic              done,
  output logic [MULT_W-1:0] mult_new
);
  localparam int unsigned MAG_W  = PPM_W + 1 + NUM_SH;
  localparam int unsigned REM_W  = $clog2(DEN) + 1;
  localparam int unsigned STEP_W = $clog2(MAG_W + 1);
  localparam logic signed [PPM_W:0] LIM_P = (PPM_W+1)'(LIMIT);
  localparam logic signed [PPM_W:0] LIM_N = -LIM_P;
  localparam longint unsigned MAX_Q = (longint'(LIMIT) << NUM_SH) / DEN;

  logic signed [PPM_W:0] s_ext, s_clip;
  logic [PPM_W:0]        s_abs;
  logic [MAG_W-1:0]      dvd_q, quo_q;
  logic [REM_W-1:0]      rem_q, rem_nx;
  logic [REM_W:0]        rem_sh;
  logic                  ge;
  logic [STEP_W-1:0]     step_q;
  logic                  neg_q, busy_q, done_q;

  always_comb begin
    s_ext = $signed({sppm[PPM_W-1], sppm});
    if (s_ext > LIM_P)      s_clip = LIM_P;
    else if (s_ext < LIM_N) s_clip = LIM_N;
    else                    s_clip = s_ext;
    s_abs = s_clip[PPM_W] ? $unsigned(-s_clip) : $unsigned(s_clip);
  end

  always_comb begin
    rem_sh = {rem_q, dvd_q[MAG_W-1]};
    ge     = (rem_sh >= (REM_W+1)'(DEN));
    rem_nx = ge ? REM_W'(rem_sh - (REM_W+1)'(DEN)) : REM_W'(rem_sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dvd_q  <= {s_abs, {NUM_SH{1'b0}}};
        quo_q  <= '0;
        rem_q  <= '0;
        step_q <= STEP_W'(MAG_W);
        neg_q  <= s_clip[PPM_W];
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q  <= dvd_q << 1;
        rem_q  <= rem_nx;
        quo_q  <= {quo_q[MAG_W-2:0], ge};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign mult_new = MULT_W'(MAG_W'(NOM) + (neg_q ? -quo_q : quo_q));

  // R7: the finished quotient never exceeds the clamped limit's image
  p_quot_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (quo_q <= MAG_W'(MAX_Q)));
  // R9: a new conversion is never started while one is running
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/tc_accum.sv
// Holds the last-fold count, the nanosecond time, the remainder and the rate word.
module tc_accum #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned NS_W   = 64,
  parameter int unsigned MULT_W = 32,
  parameter int unsigned SHIFT  = 28,
  parameter longint unsigned NOM = 64'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cyc_smp,
  input  logic [NS_W-1:0]   op_data,
  input  logic              mul_en,
  input  logic              add_en,
  input  logic              set_en,
  input  logic              adj_en,
  input  logic              load_mult,
  input  logic [MULT_W-1:0] mult_in,
  output logic [NS_W-1:0]   ns_out
);
  localparam int unsigned PROD_W = CNT_W + MULT_W + 1;

  logic [CNT_W-1:0]  last_q, delta;
  logic [NS_W-1:0]   ns_q;
  logic [SHIFT-1:0]  frac_q;
  logic [MULT_W-1:0] mult_q;
  logic [PROD_W-1:0] prod_q;

  assign delta = cyc_smp - last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      ns_q   <= '0;
      frac_q <= '0;
      mult_q <= MULT_W'(NOM);
      prod_q <= '0;
    end else begin
      if (mul_en)
        prod_q <= PROD_W'(delta) * PROD_W'(mult_q) + PROD_W'(frac_q);
      if (add_en) begin
        ns_q   <= ns_q + NS_W'(prod_q >> SHIFT);
        frac_q <= prod_q[SHIFT-1:0];
        last_q <= cyc_smp;
      end else if (set_en) begin
        ns_q   <= op_data;
        frac_q <= '0;
        last_q <= cyc_smp;
      end else if (adj_en) begin
        ns_q   <= ns_q + op_data;
      end
      if (load_mult)
        mult_q <= mult_in;
    end
  end

  assign ns_out = ns_q;

  // R8: a new rate is loaded only after the fold has latched the request's count
  p_fold_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_mult |-> (last_q == cyc_smp));
  // R5: rate word moves only on a rate load
  p_rate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_q) |-> $past(load_mult));
  // R5: offset leaves remainder and last-fold count alone
  p_adj_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adj_en |=> ($stable(last_q) && $stable(frac_q)));
  // R4: set leaves a clean remainder and the loaded time
  p_set_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((frac_q == '0) && (ns_q == $past(op_data))));
endmodule

// File: rtl/tc_ctrl.sv
// Sequences one operation at a time and owns the request/response handshake.
module tc_ctrl
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  output logic       req_ready,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       mul_en,
  output logic       add_en,
  output logic       set_en,
  output logic       adj_en,
  output logic       div_start,
  output logic       load_mult,
  input  logic       div_done
);
  tc_state_e st_q, st_d;
  tc_op_e    op_q, op_in;
  logic      accept;

  assign op_in     = tc_op_e'(req_op);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_READ;
    end else begin
      st_q <= st_d;
      if (accept) op_q <= op_in;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept)
                 st_d = ((op_in == OP_SET) || (op_in == OP_ADJ)) ? ST_EXEC : ST_MUL;
      ST_MUL:  st_d = ST_ADD;
      ST_ADD:  st_d = (op_q == OP_FINE) ? ST_DIV : ST_RESP;
      ST_EXEC: st_d = ST_RESP;
      ST_DIV:  if (div_done) st_d = ST_RESP;
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign mul_en    = (st_q == ST_MUL);
  assign add_en    = (st_q == ST_ADD);
  assign div_start = (st_q == ST_ADD) && (op_q == OP_FINE);
  assign set_en    = (st_q == ST_EXEC) && (op_q == OP_SET);
  assign adj_en    = (st_q == ST_EXEC) && (op_q == OP_ADJ);
  assign load_mult = (st_q == ST_DIV) && div_done;
  assign rsp_valid = (st_q == ST_RESP);

  // R9: once a request is taken, no other is taken on the next edge
  p_single_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10: a pending response is never withdrawn
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
endmodule

// File: rtl/cyc_ns_timecounter.sv
module cyc_ns_timecounter
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned NS_W      = 64,
  parameter int unsigned MULT_W    = 32,
  parameter int unsigned SHIFT     = 28,
  parameter int unsigned TICK_NS   = 8,
  parameter int unsigned PPM_W     = 32,
  parameter int unsigned PPM_LIMIT = 2097152000,
  parameter int unsigned NUM_SH    = 9,
  parameter int unsigned DEN       = 15625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_count,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [NS_W-1:0]  req_arg,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [NS_W-1:0]  rsp_time
);
  localparam longint unsigned NOM_MULT = longint'(TICK_NS) << SHIFT;

  logic [CNT_W-1:0]  cyc_q;
  logic [NS_W-1:0]   arg_q;
  logic              mul_en, add_en, set_en, adj_en, div_start, load_mult;
  logic              div_busy, div_done;
  logic [MULT_W-1:0] mult_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      arg_q <= '0;
    end else if (req_valid && req_ready) begin
      cyc_q <= cycle_count;
      arg_q <= req_arg;
    end
  end

  tc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .mul_en    (mul_en),
    .add_en    (add_en),
    .set_en    (set_en),
    .adj_en    (adj_en),
    .div_start (div_start),
    .load_mult (load_mult),
    .div_done  (div_done)
  );

  tc_rate_div #(
    .PPM_W  (PPM_W),
    .MULT_W (MULT_W),
    .NOM    (NOM_MULT),
    .LIMIT  (PPM_LIMIT),
    .NUM_SH (NUM_SH),
    .DEN    (DEN)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .sppm     (arg_q[PPM_W-1:0]),
    .busy     (div_busy),
    .done     (div_done),
    .mult_new (mult_new)
  );

  tc_accum #(
    .CNT_W  (CNT_W),
    .NS_W   (NS_W),
    .MULT_W (MULT_W),
    .SHIFT  (SHIFT),
    .NOM    (NOM_MULT)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_smp   (cyc_q),
    .op_data   (arg_q),
    .mul_en    (mul_en),
    .add_en    (add_en),
    .set_en    (set_en),
    .adj_en    (adj_en),
    .load_mult (load_mult),
    .mult_in   (mult_new),
    .ns_out    (rsp_time)
  );

  // R10: a stalled response keeps its value
  p_rsp_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_time)));
  // R9: the block is never idle while the converter runs
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !req_ready);
endmodule

// File: tb/cyc_ns_timecounter_test.sv
module cyc_ns_timecounter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cycle_count = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [63:0] req_arg = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_time;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [63:0] m_ns, m_last;
  logic [27:0] m_frac;
  logic [31:0] m_mult;

  always #2 clk = ~clk;

  cyc_ns_timecounter uut (
    .clk(clk), .rst_n(rst_n), .cycle_count(cycle_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_time(rsp_time)
  );

  // {op, arg, count}
  localparam int NV = 17;
  localparam logic [129:0] VEC [NV] = '{
    {2'd0, 64'd0, 64'd100},                    // R1 first read at nominal rate
    {2'd0, 64'd0, 64'd1000},                   // R2
    {2'd1, 64'd5000000000, 64'd1200},          // R4 set
    {2'd0, 64'd0, 64'd1300},                   // R4 re-latched count
    {2'd3, 64'd100, 64'd1400},                 // R8 fold then trim +3
    {2'd0, 64'd0, 64'd1401},                   // R2 remainder carry
    {2'd0, 64'd0, 64'd1402},                   // R2 remainder carry
    {2'd0, 64'd0, 64'd5000},                   // R6 trimmed rate
    {2'd2, 64'hFFFF_FFFF_FFFF_FC18, 64'd5000}, // R5 offset -1000
    {2'd3, 64'h0000_0000_FFFF_FF9C, 64'd6000}, // R8 trim -100 -> -3
    {2'd0, 64'd0, 64'd9000},                   // R6 rounding toward zero
    {2'd3, 64'h0000_0000_7FFF_FFFF, 64'd9100}, // R7 positive clamp
    {2'd0, 64'd0, 64'd109100},                 // R7
    {2'd3, 64'h0000_0000_8000_0000, 64'd109200}, // R7 negative clamp
    {2'd0, 64'd0, 64'd209200},                 // R7
    {2'd3, 64'd0, 64'd209300},                 // R6 back to nominal
    {2'd0, 64'd0, 64'd209400}                  // R6
  };

  function automatic string vec_tag(int i);
    case (i)
      0:             return "R1";
      2, 3:          return "R4";
      4, 9:          return "R8";
      7, 10, 15, 16: return "R6";
      8:             return "R5";
      11, 12, 13, 14: return "R7";
      default:       return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ns = '0; m_last = '0; m_frac = '0; m_mult = 32'h8000_0000;
  endtask

  task automatic m_accum(input logic [63:0] c);
    logic [63:0]  d;
    logic [127:0] p;
    d = c - m_last;
    p = {64'd0, d} * {96'd0, m_mult} + {100'd0, m_frac};
    m_ns   = m_ns + p[91:28];
    m_frac = p[27:0];
    m_last = c;
  endtask

  task automatic m_fine(input logic [63:0] a);
    longint s, q;
    s = longint'($signed(a[31:0]));
    if (s > 64'sd2097152000)  s = 64'sd2097152000;
    if (s < -64'sd2097152000) s = -64'sd2097152000;
    q = (s * 512) / 15625;
    m_mult = 32'(64'sh8000_0000 + q);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [63:0] arg,
                       input logic [63:0] cyc, input string tag);
    @(negedge clk);
    cycle_count = cyc; req_op = op; req_arg = arg; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    case (op)
      2'd0: m_accum(cyc);
      2'd1: begin m_ns = arg; m_last = cyc; m_frac = '0; end
      2'd2: m_ns = m_ns + arg;
      default: begin m_accum(cyc); m_fine(arg); end
    endcase
    while (!rsp_valid) @(negedge clk);
    check(tag, "time", rsp_time, m_ns);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][129:128], VEC[i][127:64], VEC[i][63:0], vec_tag(i));

    // directed: reset in mid-life returns to the initial state
    @(negedge clk); rst_n = 1'b0; cycle_count = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; m_reset();
    @(negedge clk);
    check("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    do_op(2'd0, 64'd0, 64'd50, "R1");

    // directed: counter wrap between set and read
    do_op(2'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFF6, "R3");
    do_op(2'd0, 64'd0, 64'd20, "R3");

    // directed: response stall with the next request already waiting
    @(negedge clk);
    req_op = 2'd2; req_arg = 64'd5; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    m_ns = m_ns + 64'd5;
    req_arg = 64'd7;             // second request held on the channel
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      check("R9", "req_ready during stall", 64'(req_ready), 64'd0);
      check("R10", "rsp_valid during stall", 64'(rsp_valid), 64'd1);
      check("R10", "rsp_time during stall", rsp_time, m_ns);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R10", "rsp_valid after take", 64'(rsp_valid), 64'd0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_ns = m_ns + 64'd7;
    while (!rsp_valid) @(negedge clk);
    check("R9", "second offset applied once", rsp_time, m_ns);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    do_op(2'd0, 64'd0, 64'd40, "R9");

    summary();
    $finish;
  end
endmodule